// File: doc/BRIEF.md
# Integer ALU with Decode

A combinational 32-bit integer execute unit. It takes the raw encoding fields of one instruction (opcode, funct3, funct7), the two register operand values, a 20-bit immediate field and the program counter. From these it works out the operation itself and returns the result for three groups of instructions:
- register-register arithmetic, logic, shift and compare,
- the same operations with an immediate operand,
- the two upper-immediate forms.

Any encoding outside these groups, or with a reserved field pattern, raises `illegal` and forces the result to zero.

The unit has no clock and holds no state. The result and the `illegal` flag follow the inputs in the same cycle. There is no valid/ready pair. The stage that owns the operands holds them for as long as it needs the result, so back-pressure never reaches this block. For immediate operations only bits 11:0 of `imm_field` are used; the upper-immediate forms use all 20 bits.

Top module: `intalu_exec`

## Requirements
- R1: With opcode 0x33 and funct3 0, funct7 0x00 gives `src_a + src_b` and funct7 0x20 gives `src_a - src_b`, both modulo 2^32.
- R2: funct3 4, 6 and 7 give XOR, OR and AND of `src_a` with the second operand. At opcode 0x33 the second operand is `src_b`. At opcode 0x13 it is `imm_field[11:0]` sign-extended to 32 bits.
- R3: At opcode 0x33, funct3 1 shifts `src_a` left, and funct3 5 shifts it right. The right shift is logical for funct7 0x00 and arithmetic for funct7 0x20. The shift amount is `src_b[4:0]`; higher bits of `src_b` are ignored.
- R4: At opcode 0x13 the shift amount is `imm_field[4:0]`. For funct3 5, `imm_field[10]` = 1 selects an arithmetic right shift and 0 selects a logical one.
- R5: At opcode 0x33, funct3 2 compares the operands as signed and funct3 3 compares them as unsigned. The result is 1 when `src_a` is less than `src_b`, else 0.
- R6: At opcode 0x13, funct3 2 and 3 compare `src_a` with the sign-extended 12-bit immediate, signed and unsigned respectively, giving 1 or 0.
- R7: At opcode 0x13, funct3 0 always adds the sign-extended immediate to `src_a`; no subtract exists in immediate form.
- R8: Opcode 0x37 gives `{imm_field, 12'h000}`.
- R9: Opcode 0x17 gives `pc + {imm_field, 12'h000}` modulo 2^32.
- R10: `illegal` is 1 and `result` is 0 in each of these cases:
  - an opcode other than 0x33, 0x13, 0x37 or 0x17;
  - at 0x33, a funct7 other than 0x00 or 0x20;
  - at 0x33, funct7 0x20 with a funct3 other than 0 or 5;
  - at 0x13 funct3 1, a non-zero `imm_field[11:5]`;
  - at 0x13 funct3 5, an `imm_field[11:5]` other than 0x00 or 0x20.

  In every other case `illegal` is 0.
- R11: funct7 has no effect on the result for opcodes 0x13, 0x37 and 0x17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | Operation select field |
| funct7 | input | 7 | Variant field for register-register forms |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm_field | input | 20 | Immediate; bits 11:0 for immediate forms, all bits for upper forms |
| pc | input | 32 | Program counter of the instruction |
| result | output | 32 | Computed value, zero when illegal |
| illegal | output | 1 | Encoding not supported |

## Verification
The block has no state, so a wrong decode shows at the ports in the same cycle as the inputs that cause it. It appears as a result that differs from the reference or as an `illegal` flag with the wrong value. Random operands on every supported encoding catch sign and carry errors in the adder, comparator and shifter. Directed cases cover the points where a slip hides:
- an unsigned immediate compare against an all-ones sign-extended value,
- shift amounts with high bits set,
- arithmetic shifts of negative values by 31,
- wrap-around in the PC-relative add,
- the reserved funct7 and shift-immediate patterns.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_UPPER = 7'h37;
  localparam logic [6:0] OPC_PCREL = 7'h17;

  localparam logic [6:0] F7_BASE = 7'h00;
  localparam logic [6:0] F7_ALT  = 7'h20;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_SLL,
    OP_SLT,
    OP_SLTU,
    OP_XOR,
    OP_SRL,
    OP_SRA,
    OP_OR,
    OP_AND,
    OP_UPPER,
    OP_PCREL
  } alu_op_e;
endpackage

// File: rtl/intalu_decode.sv
module intalu_decode
  import intalu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  input  logic [6:0] imm_hi,
  output alu_op_e    op,
  output logic       use_imm,
  output logic       illegal
);
  always_comb begin
    op      = OP_NONE;
    use_imm = 1'b0;
    illegal = 1'b0;
    case (opcode)
      OPC_REG: begin
        if (funct7 == F7_BASE) begin
          case (funct3)
            3'd0: op = OP_ADD;
            3'd1: op = OP_SLL;
            3'd2: op = OP_SLT;
            3'd3: op = OP_SLTU;
            3'd4: op = OP_XOR;
            3'd5: op = OP_SRL;
            3'd6: op = OP_OR;
            default: op = OP_AND;
          endcase
        end else if (funct7 == F7_ALT && funct3 == 3'd0) begin
          op = OP_SUB;
        end else if (funct7 == F7_ALT && funct3 == 3'd5) begin
          op = OP_SRA;
        end else begin
          illegal = 1'b1;
        end
      end
      OPC_IMM: begin
        use_imm = 1'b1;
        case (funct3)
          3'd0: op = OP_ADD;
          3'd1: begin
            if (imm_hi == F7_BASE) op = OP_SLL;
            else illegal = 1'b1;
          end
          3'd2: op = OP_SLT;
          3'd3: op = OP_SLTU;
          3'd4: op = OP_XOR;
          3'd5: begin
            if (imm_hi == F7_BASE)     op = OP_SRL;
            else if (imm_hi == F7_ALT) op = OP_SRA;
            else illegal = 1'b1;
          end
          3'd6: op = OP_OR;
          default: op = OP_AND;
        endcase
      end
      OPC_UPPER: op = OP_UPPER;
      OPC_PCREL: op = OP_PCREL;
      default:   illegal = 1'b1;
    endcase
    if (illegal) op = OP_NONE;
  end

  // R10: an unknown major opcode never decodes to an operation
  always_comb begin
    if (!$isunknown(opcode) && opcode != OPC_REG && opcode != OPC_IMM &&
        opcode != OPC_UPPER && opcode != OPC_PCREL) begin
      a_r10_bad_opcode: assert (illegal && op == OP_NONE)
        else $error("decode accepted opcode %h", opcode);
    end
  end
endmodule

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum
);
  logic [XLEN-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};

  // R1: subtracting a value from itself yields zero
  always_comb begin
    if (!$isunknown({a, b, sub}) && sub && a == b) begin
      a_r1_self_sub_zero: assert (sum == '0)
        else $error("self subtract gave %h", sum);
    end
  end
endmodule

// File: rtl/intalu_lessthan.sv
module intalu_lessthan #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            signed_cmp,
  output logic            lt
);
  always_comb begin
    if (signed_cmp) lt = ($signed(a) < $signed(b));
    else            lt = (a < b);
  end

  // R5: equal operands are never less-than
  always_comb begin
    if (!$isunknown({a, b, signed_cmp}) && a == b) begin
      a_r5_equal_not_less: assert (!lt)
        else $error("equal operands reported less-than");
    end
  end
endmodule

// File: rtl/intalu_shift.sv
module intalu_shift #(
  parameter int XLEN = 32,
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               left,
  input  logic               arith,
  output logic [XLEN-1:0]    dout
);
  logic [XLEN-1:0] rev_in;
  logic [XLEN-1:0] pre;
  logic [XLEN-1:0] post;
  logic [XLEN-1:0] rev_out;
  logic            fill;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = din[XLEN-1-i];
    assign rev_out[i] = post[XLEN-1-i];
  end

  assign pre  = left ? rev_in : din;
  assign fill = arith & ~left & din[XLEN-1];

  for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    logic [XLEN-1:0] src;
    logic [XLEN-1:0] nxt;
    if (g == 0) begin : g_first
      assign src = pre;
    end else begin : g_chain
      assign src = g_stage[g-1].nxt;
    end
    assign nxt = amt[g] ? {{STEP{fill}}, src[XLEN-1:STEP]} : src;
  end

  assign post = g_stage[SHAMT_W-1].nxt;
  assign dout = left ? rev_out : post;

  always_comb begin
    if (!$isunknown({din, amt, left, arith}) && amt != '0) begin
      // R3: a non-zero left shift clears bit 0
      if (left) begin
        a_r3_left_fill_zero: assert (dout[0] == 1'b0)
          else $error("left shift left bit 0 set");
      end
      // R4: an arithmetic right shift keeps the sign bit
      if (!left && arith) begin
        a_r4_arith_keeps_sign: assert (dout[XLEN-1] == din[XLEN-1])
          else $error("arithmetic shift lost sign");
      end
    end
  end
endmodule

// File: rtl/intalu_exec.sv
module intalu_exec
  import intalu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 12,
  parameter int UIMM_W = 20,
  localparam int SHAMT_W = $clog2(XLEN),
  localparam int ULOW_W  = XLEN - UIMM_W
) (
  input  logic [6:0]        opcode,
  input  logic [2:0]        funct3,
  input  logic [6:0]        funct7,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [UIMM_W-1:0] imm_field,
  input  logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   result,
  output logic              illegal
);
  alu_op_e         op;
  logic            use_imm;
  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] upper;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] add_a;
  logic [XLEN-1:0] add_b;
  logic [XLEN-1:0] add_out;
  logic [XLEN-1:0] sh_out;
  logic            lt;

  intalu_decode u_decode (
    .opcode  (opcode),
    .funct3  (funct3),
    .funct7  (funct7),
    .imm_hi  (imm_field[IMM_W-1:IMM_W-7]),
    .op      (op),
    .use_imm (use_imm),
    .illegal (illegal)
  );

  assign imm_sext = {{(XLEN-IMM_W){imm_field[IMM_W-1]}}, imm_field[IMM_W-1:0]};
  assign upper    = {imm_field, {ULOW_W{1'b0}}};
  assign opnd_b   = use_imm ? imm_sext : src_b;

  assign add_a = (op == OP_PCREL) ? pc    : src_a;
  assign add_b = (op == OP_PCREL) ? upper : opnd_b;

  intalu_addsub #(.XLEN(XLEN)) u_addsub (
    .a   (add_a),
    .b   (add_b),
    .sub (op == OP_SUB),
    .sum (add_out)
  );

  intalu_lessthan #(.XLEN(XLEN)) u_lt (
    .a          (src_a),
    .b          (opnd_b),
    .signed_cmp (op == OP_SLT),
    .lt         (lt)
  );

  intalu_shift #(.XLEN(XLEN)) u_shift (
    .din   (src_a),
    .amt   (opnd_b[SHAMT_W-1:0]),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .dout  (sh_out)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_PCREL: result = add_out;
      OP_SLL, OP_SRL, OP_SRA:   result = sh_out;
      OP_SLT, OP_SLTU:          result = {{(XLEN-1){1'b0}}, lt};
      OP_XOR:                   result = src_a ^ opnd_b;
      OP_OR:                    result = src_a | opnd_b;
      OP_AND:                   result = src_a & opnd_b;
      OP_UPPER:                 result = upper;
      default:                  result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opcode, funct3, funct7, src_a, src_b, imm_field, pc})) begin
      // R10: a rejected encoding produces a zero result
      if (illegal) begin
        a_r10_quiet_result: assert (result == '0)
          else $error("illegal encoding gave %h", result);
      end
      // R8: the upper-immediate form has clear low bits
      if (opcode == OPC_UPPER) begin
        a_r8_upper_low_zero: assert (result[ULOW_W-1:0] == '0 && !illegal)
          else $error("upper immediate low bits %h", result);
      end
    end
  end
endmodule

// File: tb/intalu_exec_tb.sv
module intalu_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [19:0] imm_field = '0;
  logic [31:0] pc = '0;
  logic [31:0] result;
  logic        illegal;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  intalu_exec u_dut (
    .opcode    (opcode),
    .funct3    (funct3),
    .funct7    (funct7),
    .src_a     (src_a),
    .src_b     (src_b),
    .imm_field (imm_field),
    .pc        (pc),
    .result    (result),
    .illegal   (illegal)
  );

  function automatic void model(input logic [6:0] opc, input logic [2:0] f3,
                                input logic [6:0] f7, input logic [31:0] a,
                                input logic [31:0] b, input logic [19:0] im,
                                input logic [31:0] p, output logic [31:0] r,
                                output logic ill);
    logic [31:0] s;
    int sh;
    s   = {{20{im[11]}}, im[11:0]};
    r   = '0;
    ill = 1'b0;
    if (opc == 7'h33) begin
      sh = int'(b[4:0]);
      if (f7 == 7'h00) begin
        case (f3)
          3'd0: r = a + b;
          3'd1: r = a << sh;
          3'd2: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          3'd3: r = (a < b) ? 32'd1 : 32'd0;
          3'd4: r = a ^ b;
          3'd5: r = a >> sh;
          3'd6: r = a | b;
          default: r = a & b;
        endcase
      end else if (f7 == 7'h20 && f3 == 3'd0) r = a - b;
      else if (f7 == 7'h20 && f3 == 3'd5) r = $signed(a) >>> sh;
      else ill = 1'b1;
    end else if (opc == 7'h13) begin
      sh = int'(im[4:0]);
      case (f3)
        3'd0: r = a + s;
        3'd1: if (im[11:5] == 7'h00) r = a << sh; else ill = 1'b1;
        3'd2: r = ($signed(a) < $signed(s)) ? 32'd1 : 32'd0;
        3'd3: r = (a < s) ? 32'd1 : 32'd0;
        3'd4: r = a ^ s;
        3'd5: begin
          if (im[11:5] == 7'h00) r = a >> sh;
          else if (im[11:5] == 7'h20) r = $signed(a) >>> sh;
          else ill = 1'b1;
        end
        3'd6: r = a | s;
        default: r = a & s;
      endcase
    end else if (opc == 7'h37) r = {im, 12'h000};
    else if (opc == 7'h17) r = p + {im, 12'h000};
    else ill = 1'b1;
    if (ill) r = '0;
  endfunction

  function automatic string tag_of(input logic [6:0] opc, input logic [2:0] f3, input bit ill);
    if (ill) return "R10";
    if (opc == 7'h37) return "R8";
    if (opc == 7'h17) return "R9";
    if (opc == 7'h33) begin
      if (f3 == 3'd0) return "R1";
      if (f3 == 3'd1 || f3 == 3'd5) return "R3";
      if (f3 == 3'd2 || f3 == 3'd3) return "R5";
      return "R2";
    end
    if (f3 == 3'd0) return "R7";
    if (f3 == 3'd1 || f3 == 3'd5) return "R4";
    if (f3 == 3'd2 || f3 == 3'd3) return "R6";
    return "R2";
  endfunction

  task automatic apply(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [31:0] a, input logic [31:0] b, input logic [19:0] im,
                       input logic [31:0] p, input string tag);
    logic [31:0] exp_r;
    logic        exp_i;
    string       t;
    @(posedge clk);
    opcode = opc; funct3 = f3; funct7 = f7;
    src_a = a; src_b = b; imm_field = im; pc = p;
    model(opc, f3, f7, a, b, im, p, exp_r, exp_i);
    t = (tag == "") ? tag_of(opc, f3, exp_i) : tag;
    @(negedge clk);
    n_run++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_fail++;
      $display("FAIL %s op=%h f3=%0d f7=%h a=%h b=%h imm=%h: got %h/%b expected %h/%b",
               t, opc, f3, f7, a, b, im, result, illegal, exp_r, exp_i);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle all-zero inputs are an unsupported opcode
    apply(7'h00, 3'd0, 7'h00, 32'h0, 32'h0, 20'h0, 32'h0, "R10");
    // R1: wrap on add and subtract
    apply(7'h33, 3'd0, 7'h00, 32'hFFFF_FFFF, 32'h1, 20'h0, 32'h0, "R1");
    apply(7'h33, 3'd0, 7'h20, 32'h0, 32'h1, 20'h0, 32'h0, "R1");
    // R3: only the low five bits of src_b count
    apply(7'h33, 3'd1, 7'h00, 32'h0000_0001, 32'hFFFF_FFE3, 20'h0, 32'h0, "R3");
    apply(7'h33, 3'd5, 7'h20, 32'h8000_0000, 32'd31, 20'h0, 32'h0, "R3");
    apply(7'h33, 3'd5, 7'h00, 32'h8000_0000, 32'd31, 20'h0, 32'h0, "R3");
    // R4: imm bit 10 picks arithmetic right shift
    apply(7'h13, 3'd5, 7'h00, 32'h8000_0000, 32'h0, 20'h0041F, 32'h0, "R4");
    apply(7'h13, 3'd5, 7'h00, 32'h8000_0000, 32'h0, 20'h0001F, 32'h0, "R4");
    // R5: signed versus unsigned
    apply(7'h33, 3'd2, 7'h00, 32'hFFFF_FFFF, 32'h1, 20'h0, 32'h0, "R5");
    apply(7'h33, 3'd3, 7'h00, 32'hFFFF_FFFF, 32'h1, 20'h0, 32'h0, "R5");
    // R6: unsigned compare against sign-extended all-ones immediate
    apply(7'h13, 3'd3, 7'h00, 32'd5, 32'h0, 20'h00FFF, 32'h0, "R6");
    apply(7'h13, 3'd2, 7'h00, 32'd5, 32'h0, 20'h00FFF, 32'h0, "R6");
    // R7: immediate add with negative immediate, never subtract
    apply(7'h13, 3'd0, 7'h20, 32'd10, 32'h0, 20'h00FFE, 32'h0, "R7");
    // R2: immediate logic with sign extension
    apply(7'h13, 3'd7, 7'h00, 32'h1234_5678, 32'h0, 20'h00800, 32'h0, "R2");
    // R8 / R9
    apply(7'h37, 3'd0, 7'h00, 32'h0, 32'h0, 20'hABCDE, 32'h0, "R8");
    apply(7'h17, 3'd0, 7'h00, 32'h0, 32'h0, 20'h00001, 32'hFFFF_F000, "R9");
    // R10: reserved patterns
    apply(7'h33, 3'd0, 7'h01, 32'h5, 32'h6, 20'h0, 32'h0, "R10");
    apply(7'h33, 3'd4, 7'h20, 32'h5, 32'h6, 20'h0, 32'h0, "R10");
    apply(7'h13, 3'd5, 7'h00, 32'h5, 32'h0, 20'h00421, 32'h0, "R10");
    apply(7'h13, 3'd1, 7'h00, 32'h5, 32'h0, 20'h00401, 32'h0, "R10");
    apply(7'h03, 3'd0, 7'h00, 32'h5, 32'h0, 20'h0, 32'h0, "R10");
    // R11: funct7 ignored outside register-register
    apply(7'h13, 3'd0, 7'h7F, 32'd3, 32'h0, 20'h00004, 32'h0, "R11");
    apply(7'h37, 3'd0, 7'h20, 32'd0, 32'h0, 20'h12345, 32'h0, "R11");
    apply(7'h17, 3'd5, 7'h55, 32'd0, 32'h0, 20'h00010, 32'h0000_1000, "R11");
    // Random sweep over every encoding group
    for (int k = 0; k < 4000; k++) begin
      logic [6:0] opc;
      logic [6:0] f7;
      logic [19:0] im;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2, 3: opc = 7'h33;
        4, 5, 6:    opc = 7'h13;
        7:          opc = 7'h37;
        8:          opc = 7'h17;
        default:    opc = 7'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0, 1, 2: f7 = 7'h00;
        3, 4:    f7 = 7'h20;
        default: f7 = 7'($urandom);
      endcase
      im = 20'($urandom);
      if (opc == 7'h13 && $urandom_range(0, 3) != 0)
        im[11:5] = ($urandom_range(0, 1) == 0) ? 7'h00 : 7'h20;
      apply(opc, 3'($urandom), f7, $urandom, $urandom, im, $urandom, "");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule